// File: doc/BRIEF.md
# Selective Harmonic Phasor Extractor

This block turns one phase of a three-phase voltage/current sample stream into running complex phasors at a handful of chosen frequencies. The frequencies are the fundamental and up to three harmonic orders, one per harmonic slot, that software picks. Each analysis frequency is locked to a tracked fundamental phase supplied with every sample, so the bins follow the grid frequency as it drifts. Every slot keeps a single-bin DFT that is updated recursively on each sample through a first-order leaky integrator. New results are therefore produced per sample and not per block.

All four slots share one multiplier. After a sample is accepted, the slots are visited in order from 0 (the fundamental) to 3. Each enabled slot takes four multiply-update cycles, for voltage and current times cosine and minus sine, and is then offered on the result stream. A slot stays silent for a programmable number of samples after its accumulators are cleared. A clear happens when the analysed phase or the slot's harmonic order changes.

Both data edges are valid/ready streams. The input stream applies back-pressure: `s_ready` is high only while no sample is in flight, and it stays low until every result for the current sample has been taken. The result stream holds its payload steady while `m_valid` is high and `m_ready` is low. The configuration pins are plain levels and are sampled once, when a sample is accepted.

Top module: `harmonic_bin_extractor`

## Requirements
- R1: A sample is taken on a clock edge with `s_valid` and `s_ready` both high. `s_ready` is low from the next cycle until all results for that sample have left, so only one sample is ever in flight.
- R2: Once `m_valid` is high it stays high, with `m_slot`, `m_order` and all four phasor values unchanged, until a cycle with `m_ready` high. Within one sample, results leave in ascending slot order. Slot 0 always reports order 1.
- R3: `cfg_phase` picks the analysed phase for both voltage and current. Code 0 selects A, 1 selects B, 2 selects C, and code 3 behaves exactly as code 0.
- R4: The reference angle of a slot with order k is k·`s_theta` mod 2^32. Its bits [31:24] form an 8-bit index a. Let T(i) = floor(32767·16·i·(128−i) / (81920 − 4·i·(128−i))) for i = 0..64. Then sin(a) = ±T(j): j is a[5:0] when a[6]=0 and 64−a[5:0] when a[6]=1, and the sign is negative when a[7]=1. cos(a) = sin((a+64) mod 256).
- R5: For each sample, each enabled slot updates every accumulator as acc ← acc + ((p − acc) >>> SHIFT). Here p = (x·t) >>> 15 with arithmetic shifts. The real parts use t = cos and the imaginary parts use t = −sin. x is the selected voltage for `m_v_*` and the selected current for `m_i_*`. The accumulators are 18 bits wide for 16-bit samples.
- R6: A harmonic slot whose 6-bit order field in `cfg_orders` (slot h at bits [6h−1:6h−6]) is 0 produces no result and does not change its accumulators.
- R7: At the first sample after reset, all accumulators are zeroed before the update. A change in the effective phase zeroes all of them. A change in a slot's order zeroes only that slot's accumulators.
- R8: After a slot is cleared, that slot produces no result for HOLD samples (default 4096), counting the sample that caused the clear. Other slots are unaffected.
- R9: During and right after reset, `s_ready` is high and `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Block can take a sample |
| s_volt_a | input | DATA_W | Phase A voltage, signed |
| s_volt_b | input | DATA_W | Phase B voltage, signed |
| s_volt_c | input | DATA_W | Phase C voltage, signed |
| s_curr_a | input | DATA_W | Phase A current, signed |
| s_curr_b | input | DATA_W | Phase B current, signed |
| s_curr_c | input | DATA_W | Phase C current, signed |
| s_theta | input | 32 | Tracked fundamental phase, full circle = 2^32 |
| cfg_phase | input | 2 | Analysed phase select |
| cfg_orders | input | 6·N_HARM | Harmonic order per slot, 0 disables |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Consumer takes result |
| m_slot | output | 2 | Slot index of the result |
| m_order | output | 6 | Harmonic order of the result |
| m_v_re | output | DATA_W+2 | Voltage phasor, real part |
| m_v_im | output | DATA_W+2 | Voltage phasor, imaginary part |
| m_i_re | output | DATA_W+2 | Current phasor, real part |
| m_i_im | output | DATA_W+2 | Current phasor, imaginary part |

## Verification
A corrupted accumulator does not go away after one sample. The leaky update only shrinks the error by a factor of 1 − 2^−SHIFT per sample, so a single wrong value keeps showing in that slot's phasors on every later result until the next clear. A wrong clear or hold decision shows at once as a missing or extra result in the very next sample's burst. A wrong angle or table value shows within one sample as a phasor mismatch on that slot alone. For this reason the bench compares every result against a bit-exact reference model, and also compares the number of results each sample yields.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  localparam int TRIG_W  = 16;   // sine/cosine sample width, Q15
  localparam int ORD_W   = 6;    // harmonic order field width
  localparam int ANG_W   = 32;   // phase word width
  localparam int IDX_W   = 8;    // angle bits used for the lookup
  localparam int QTR     = 64;   // quarter-wave table steps

  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_OUT} hpe_state_e;

  // Rational sine approximation over one quarter wave, scaled to 32767.
  function automatic logic signed [TRIG_W-1:0] quarter_sine(input int idx);
    longint span, num, den;
    span = longint'(idx) * longint'(2 * QTR - idx);
    num  = 64'sd32767 * 64'sd16 * span;
    den  = 64'sd5 * (2 * QTR) * (2 * QTR) - 64'sd4 * span;
    return TRIG_W'(num / den);
  endfunction
endpackage

// File: rtl/hpe_trig.sv
module hpe_trig
  import hpe_pkg::*;
(
  input  logic [IDX_W-1:0]         idx,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  logic signed [TRIG_W-1:0] tbl [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : g_tbl
    assign tbl[g] = quarter_sine(g);
  end

  function automatic logic signed [TRIG_W-1:0] lookup(input logic [IDX_W-1:0] a);
    logic [6:0] j;
    logic signed [TRIG_W-1:0] mag;
    j   = a[6] ? (7'd64 - {1'b0, a[5:0]}) : {1'b0, a[5:0]};
    mag = tbl[j];
    return a[7] ? -mag : mag;
  endfunction

  always_comb begin
    sin_o = lookup(idx);
    cos_o = lookup(idx + 8'd64);
  end
endmodule

// File: rtl/hpe_mac.sv
module hpe_mac
  import hpe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 10,
  localparam int ACC_W = DATA_W + 2
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [TRIG_W-1:0] ref_i,
  input  logic                     negate,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int W = DATA_W + TRIG_W + 1;
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(2 ** DATA_W);

  logic signed [TRIG_W:0] t_eff;
  logic signed [W-1:0]    prod, scaled, diff, stepv;

  always_comb begin
    t_eff = ref_i;
    if (negate) t_eff = -t_eff;
    prod   = x * t_eff;
    scaled = prod >>> (TRIG_W - 1);
    diff   = scaled - W'(acc_i);
    stepv  = diff >>> SHIFT;
    acc_o  = ACC_W'(W'(acc_i) + stepv);
  end

  // leaky update never leaves the accumulator range
  always_comb begin
    if (acc_i >= -LIM && acc_i <= LIM)
      AST_NO_OVERFLOW: assert (acc_o >= -LIM && acc_o <= LIM); // R5
  end
endmodule

// File: rtl/harmonic_bin_extractor.sv
module harmonic_bin_extractor
  import hpe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_HARM = 3,
  parameter int SHIFT  = 10,
  parameter int HOLD   = 4096
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  s_valid,
  output logic                                  s_ready,
  input  logic signed [DATA_W-1:0]              s_volt_a,
  input  logic signed [DATA_W-1:0]              s_volt_b,
  input  logic signed [DATA_W-1:0]              s_volt_c,
  input  logic signed [DATA_W-1:0]              s_curr_a,
  input  logic signed [DATA_W-1:0]              s_curr_b,
  input  logic signed [DATA_W-1:0]              s_curr_c,
  input  logic [ANG_W-1:0]                      s_theta,
  input  logic [1:0]                            cfg_phase,
  input  logic [N_HARM*ORD_W-1:0]               cfg_orders,
  output logic                                  m_valid,
  input  logic                                  m_ready,
  output logic [$clog2(N_HARM+1)-1:0]           m_slot,
  output logic [ORD_W-1:0]                      m_order,
  output logic signed [DATA_W+1:0]              m_v_re,
  output logic signed [DATA_W+1:0]              m_v_im,
  output logic signed [DATA_W+1:0]              m_i_re,
  output logic signed [DATA_W+1:0]              m_i_im
);
  localparam int NSLOT  = N_HARM + 1;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int ACC_W  = DATA_W + 2;
  localparam int HOLD_W = $clog2(HOLD + 1);

  hpe_state_e               state_q;
  logic [SLOT_W-1:0]        slot_q;
  logic [1:0]               step_q;
  logic signed [DATA_W-1:0] v_q, i_q;
  logic [ANG_W-1:0]         th_q;
  logic [1:0]               phase_q;
  logic                     first_q;
  logic [ORD_W-1:0]         ord_q [NSLOT];
  logic [HOLD_W-1:0]        rem_q [NSLOT];
  logic [NSLOT-1:0]         sup_q;
  logic signed [ACC_W-1:0]  acc_q [NSLOT][4];

  // ---- configuration snapshot and clear decisions ----
  logic [1:0]               phase_eff;
  logic [ORD_W-1:0]         new_ord [NSLOT];
  logic [NSLOT-1:0]         clr;
  logic signed [DATA_W-1:0] sel_v, sel_i;

  assign phase_eff  = (cfg_phase == 2'd3) ? 2'd0 : cfg_phase;
  assign new_ord[0] = ORD_W'(1);
  for (genvar h = 1; h < NSLOT; h++) begin : g_ord
    assign new_ord[h] = cfg_orders[(h-1)*ORD_W +: ORD_W];
  end
  for (genvar s = 0; s < NSLOT; s++) begin : g_clr
    assign clr[s] = first_q || (phase_eff != phase_q) || (new_ord[s] != ord_q[s]);
  end

  always_comb begin
    case (phase_eff)
      2'd1:    begin sel_v = s_volt_b; sel_i = s_curr_b; end
      2'd2:    begin sel_v = s_volt_c; sel_i = s_curr_c; end
      default: begin sel_v = s_volt_a; sel_i = s_curr_a; end
    endcase
  end

  // ---- shared reference and multiplier ----
  logic [ORD_W-1:0]         cur_ord;
  logic [IDX_W-1:0]         ang_idx;
  logic signed [TRIG_W-1:0] sin_w, cos_w;
  logic signed [ACC_W-1:0]  mac_out;
  logic                     slot_last;

  assign cur_ord   = ord_q[slot_q];
  assign ang_idx   = IDX_W'((th_q * ANG_W'(cur_ord)) >> (ANG_W - IDX_W));
  assign slot_last = (slot_q == SLOT_W'(NSLOT - 1));

  hpe_trig u_trig (
    .idx   (ang_idx),
    .sin_o (sin_w),
    .cos_o (cos_w)
  );

  hpe_mac #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_mac (
    .x      (step_q[1] ? i_q : v_q),
    .ref_i  (step_q[0] ? sin_w : cos_w),
    .negate (step_q[0]),
    .acc_i  (acc_q[slot_q][step_q]),
    .acc_o  (mac_out)
  );

  // ---- sequencer ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      step_q  <= '0;
      v_q     <= '0;
      i_q     <= '0;
      th_q    <= '0;
      phase_q <= '0;
      first_q <= 1'b1;
      sup_q   <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        ord_q[s] <= '0;
        rem_q[s] <= '0;
        for (int k = 0; k < 4; k++) acc_q[s][k] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: if (s_valid) begin
          v_q     <= sel_v;
          i_q     <= sel_i;
          th_q    <= s_theta;
          phase_q <= phase_eff;
          first_q <= 1'b0;
          slot_q  <= '0;
          step_q  <= '0;
          state_q <= ST_MAC;
          for (int s = 0; s < NSLOT; s++) begin
            ord_q[s] <= new_ord[s];
            if (clr[s]) begin
              for (int k = 0; k < 4; k++) acc_q[s][k] <= '0;
              rem_q[s] <= HOLD_W'(HOLD - 1);
              sup_q[s] <= 1'b1;
            end else if (rem_q[s] != '0) begin
              rem_q[s] <= rem_q[s] - HOLD_W'(1);
              sup_q[s] <= 1'b1;
            end else begin
              sup_q[s] <= 1'b0;
            end
          end
        end
        ST_MAC: begin
          if (cur_ord == '0) begin
            if (slot_last) state_q <= ST_IDLE;
            else           slot_q  <= slot_q + SLOT_W'(1);
          end else begin
            acc_q[slot_q][step_q] <= mac_out;
            step_q <= step_q + 2'd1;
            if (step_q == 2'd3) begin
              if (!sup_q[slot_q])  state_q <= ST_OUT;
              else if (slot_last)  state_q <= ST_IDLE;
              else                 slot_q  <= slot_q + SLOT_W'(1);
            end
          end
        end
        ST_OUT: if (m_ready) begin
          if (slot_last) state_q <= ST_IDLE;
          else begin
            slot_q  <= slot_q + SLOT_W'(1);
            state_q <= ST_MAC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ready = (state_q == ST_IDLE);
  assign m_valid = (state_q == ST_OUT);
  assign m_slot  = slot_q;
  assign m_order = cur_ord;
  assign m_v_re  = acc_q[slot_q][0];
  assign m_v_im  = acc_q[slot_q][1];
  assign m_i_re  = acc_q[slot_q][2];
  assign m_i_im  = acc_q[slot_q][3];

  // ---- properties ----
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> !s_ready); // R1
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R1
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_slot) && $stable(m_order) &&
      $stable(m_v_re) && $stable(m_v_im) && $stable(m_i_re) && $stable(m_i_im)); // R2
  AST_FUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_slot == '0 |-> m_order == ORD_W'(1)); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_order != '0); // R6
  AST_CLEARED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> rem_q[m_slot] != HOLD_W'(HOLD - 1) || HOLD == 1 && !sup_q[m_slot]); // R8
endmodule

// File: tb/harmonic_bin_extractor_tb.sv
`timescale 1ns/1ps
module harmonic_bin_extractor_tb;
  localparam int DW = 16, NH = 3, SH = 3, HD = 8, NS = NH + 1, AW = DW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b0;
  logic signed [DW-1:0] s_volt_a = '0, s_volt_b = '0, s_volt_c = '0;
  logic signed [DW-1:0] s_curr_a = '0, s_curr_b = '0, s_curr_c = '0;
  logic [31:0] s_theta = '0;
  logic [1:0]  cfg_phase = '0;
  logic [NH*6-1:0] cfg_orders = '0;
  logic [1:0] m_slot;
  logic [5:0] m_order;
  logic signed [AW-1:0] m_v_re, m_v_im, m_i_re, m_i_im;

  harmonic_bin_extractor #(.DATA_W(DW), .N_HARM(NH), .SHIFT(SH), .HOLD(HD)) u_dut (
    .clk, .rst_n, .s_valid, .s_ready, .s_volt_a, .s_volt_b, .s_volt_c,
    .s_curr_a, .s_curr_b, .s_curr_c, .s_theta, .cfg_phase, .cfg_orders,
    .m_valid, .m_ready, .m_slot, .m_order, .m_v_re, .m_v_im, .m_i_re, .m_i_im);

  int checks = 0, errors = 0;

  // ---- reference model ----
  longint macc [NS][4];
  int     mrem [NS];
  int     mord [NS];
  int     mphase = 0;
  bit     mfirst = 1'b1;
  int     exp_n;
  int     exp_slot [NS];
  int     exp_ord  [NS];
  longint exp_val  [NS][4];

  function automatic longint qsin(int i);
    longint sp;
    sp = longint'(i) * longint'(128 - i);
    return (64'sd32767 * 16 * sp) / (64'sd81920 - 4 * sp);
  endfunction

  function automatic longint sin8(int a);
    int q, j;
    longint mag;
    q = (a >> 6) & 3;
    j = a & 63;
    mag = (q & 1) ? qsin(64 - j) : qsin(j);
    return (q & 2) ? -mag : mag;
  endfunction

  function automatic longint leak(longint a, longint x, longint t);
    longint sc;
    sc = (x * t) >>> 15;
    return a + ((sc - a) >>> SH);
  endfunction

  function automatic void model_step(int ph_raw, logic [NH*6-1:0] ords,
                                     int va, int vb, int vc, int ia, int ib, int ic,
                                     logic [31:0] th);
    int ph, xv, xi, o, a;
    bit sup [NS];
    longint c, sn;
    ph = (ph_raw == 3) ? 0 : ph_raw;
    xv = (ph == 1) ? vb : (ph == 2) ? vc : va;
    xi = (ph == 1) ? ib : (ph == 2) ? ic : ia;
    exp_n = 0;
    for (int s = 0; s < NS; s++) begin
      o = (s == 0) ? 1 : int'(ords[(s-1)*6 +: 6]);
      if (mfirst || ph != mphase || o != mord[s]) begin
        for (int k = 0; k < 4; k++) macc[s][k] = 0;
        mrem[s] = HD - 1;
        sup[s] = 1'b1;
      end else if (mrem[s] != 0) begin
        mrem[s]--;
        sup[s] = 1'b1;
      end else sup[s] = 1'b0;
      mord[s] = o;
    end
    for (int s = 0; s < NS; s++) begin
      if (mord[s] != 0) begin
        a  = int'(((longint'(th) * mord[s]) & 64'hFFFF_FFFF) >> 24);
        c  = sin8((a + 64) & 255);
        sn = sin8(a);
        macc[s][0] = leak(macc[s][0], xv, c);
        macc[s][1] = leak(macc[s][1], xv, -sn);
        macc[s][2] = leak(macc[s][2], xi, c);
        macc[s][3] = leak(macc[s][3], xi, -sn);
        if (!sup[s]) begin
          exp_slot[exp_n] = s;
          exp_ord[exp_n]  = mord[s];
          for (int k = 0; k < 4; k++) exp_val[exp_n][k] = macc[s][k];
          exp_n++;
        end
      end
    end
    mphase = ph;
    mfirst = 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_sample(int va, int vb, int vc, int ia, int ib, int ic,
                            logic [31:0] th, int pct);
    int got, guard;
    bit stall, done;
    logic [1:0] sv_slot;
    logic [5:0] sv_ord;
    longint sv [4];
    longint cur [4];
    model_step(int'(cfg_phase), cfg_orders, va, vb, vc, ia, ib, ic, th);
    @(negedge clk);
    s_volt_a = DW'(va); s_volt_b = DW'(vb); s_volt_c = DW'(vc);
    s_curr_a = DW'(ia); s_curr_b = DW'(ib); s_curr_c = DW'(ic);
    s_theta = th;
    s_valid = 1'b1;
    check(s_ready === 1'b1, "R1", "ready while idle", longint'(s_ready), 1);
    @(negedge clk);
    s_valid = 1'b0;
    check(s_ready === 1'b0, "R1", "ready while busy", longint'(s_ready), 0);
    got = 0; guard = 0; stall = 1'b0; done = 1'b0;
    while (!done) begin
      m_ready = (($urandom % 100) < pct);
      cur[0] = m_v_re; cur[1] = m_v_im; cur[2] = m_i_re; cur[3] = m_i_im;
      if (stall)
        check(m_valid && m_slot == sv_slot && m_order == sv_ord && cur[0] == sv[0] &&
              cur[1] == sv[1] && cur[2] == sv[2] && cur[3] == sv[3],
              "R2", "payload held under back-pressure", cur[0], sv[0]);
      stall = 1'b0;
      if (m_valid) begin
        if (m_ready) begin
          if (got < exp_n) begin
            check(int'(m_slot) == exp_slot[got] && int'(m_order) == exp_ord[got],
                  "R2", "slot sequence", longint'(m_slot), exp_slot[got]);
            for (int k = 0; k < 4; k++)
              check(cur[k] == exp_val[got][k], "R4 R5", "phasor part", cur[k], exp_val[got][k]);
          end else
            check(1'b0, "R6 R8", "unexpected result slot", longint'(m_slot), -1);
          got++;
        end else begin
          stall = 1'b1;
          sv_slot = m_slot; sv_ord = m_order;
          for (int k = 0; k < 4; k++) sv[k] = cur[k];
        end
      end
      if (!m_valid && s_ready) done = 1'b1;
      else begin
        @(negedge clk);
        guard++;
        if (guard > 2000) begin
          check(1'b0, "R1", "sample never completed", guard, 0);
          done = 1'b1;
        end
      end
    end
    m_ready = 1'b0;
    check(got == exp_n, "R6 R7 R8", "results per sample", got, exp_n);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  int ph_i;
  logic [31:0] th;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(s_ready === 1'b1, "R9", "s_ready in reset", longint'(s_ready), 1);
    check(m_valid === 1'b0, "R9", "m_valid in reset", longint'(m_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready === 1'b1 && m_valid === 1'b0, "R9", "idle after reset", longint'(m_valid), 0);

    // fundamental only, DC input at zero angle; first HD samples silent
    cfg_phase = 2'd0; cfg_orders = '0; th = 32'd0;
    for (int n = 0; n < HD + 6; n++) run_sample(1000, 7, 9, -500, 3, 5, th, 100);

    // phase B, rotating angle
    cfg_phase = 2'd1;
    for (int n = 0; n < HD + 6; n++) begin
      th += 32'd26843546;
      run_sample(111, 20000 - n * 300, -77, 55, -9000 + n * 100, 66, th, 60);
    end

    // phase C then code 3 (acts as A, clears once), then A again (no clear)
    cfg_phase = 2'd2;
    for (int n = 0; n < 3; n++) begin th += 32'd40000000; run_sample(1, 2, 30000, 4, 5, -30000, th, 50); end
    cfg_phase = 2'd3;
    for (int n = 0; n < HD + 3; n++) begin th += 32'd40000000; run_sample(-12000, 5, 5, 8000, 5, 5, th, 70); end
    cfg_phase = 2'd0;
    run_sample(-12000, 5, 5, 8000, 5, 5, th, 70);
    check(exp_n == NS - 3, "R3", "code 3 then 0 keeps accumulators", exp_n, NS - 3);

    // harmonics including order 63 and angle wrap
    cfg_orders = {6'd5, 6'd63, 6'd2};
    th = 32'hFF00_0000;
    for (int n = 0; n < HD + 4; n++) begin
      th += 32'd53687091;
      run_sample(-32768, 0, 0, 32767, 0, 0, th, 40);
    end
    // change only slot 2's order: that slot alone goes silent
    cfg_orders = {6'd5, 6'd3, 6'd2};
    for (int n = 0; n < HD + 2; n++) begin
      th += 32'd53687091;
      run_sample(15000, 0, 0, -15000, 0, 0, th, 80);
      if (n == 0) check(exp_n == 3, "R7", "other slots keep reporting", exp_n, 3);
    end
    // disable one slot
    cfg_orders = {6'd5, 6'd0, 6'd2};
    for (int n = 0; n < 3; n++) begin th += 32'd53687091; run_sample(999, 0, 0, 111, 0, 0, th, 90); end
    check(exp_n == 3, "R6", "disabled slot silent", exp_n, 3);

    // constrained random
    for (int n = 0; n < 220; n++) begin
      if ($urandom % 100 < 4) cfg_phase = 2'($urandom % 4);
      if ($urandom % 100 < 6) begin
        ph_i = int'($urandom % NH);
        cfg_orders[ph_i*6 +: 6] = 6'($urandom % 64);
      end
      th += 32'd26000000 + ($urandom % 2000000);
      run_sample(int'($urandom % 40001) - 20000, int'($urandom % 40001) - 20000,
                 int'($urandom % 40001) - 20000, int'($urandom % 40001) - 20000,
                 int'($urandom % 40001) - 20000, int'($urandom % 40001) - 20000,
                 th, 30 + int'($urandom % 71));
    end
    finish_run();
  end
endmodule